// File: doc/BRIEF.md
# E1 Remote Alarm Bit Generator

This block produces the remote alarm indication bit that an E1 transmit framer places in bit 3 of time slot 0 of every frame that does not carry the frame alignment signal. The bit is 0 while the near-end receiver sees a clean line. It goes to 1 when software forces it, or when one of several receive conditions is active and that condition's enable bit is set in an 8-bit control word. The maskable conditions are: loss of basic frame alignment, loss of CRC-4 multiframe alignment, loss of CRC-4 multiframe alignment after the multiframe search timer has expired, loss of time slot 16 signalling multiframe alignment, and two decoded Sa6 patterns.

Basic frame alignment can be lost in two ways. The receive framer can report framing bit errors, or the block's own CRC-4 errored-block monitor can declare the loss. The monitor counts received CRC-4 sub-multiframe blocks in windows of 1000. It declares loss when at least 915 blocks of a window are errored. The declaration holds until the framer reports that alignment has been regained.

The transmit framer pulses a strobe at the start of time slot 0 of each NOT FAS frame. The alarm bit is captured on that strobe and held until the next one, so its value never changes inside a transmitted bit.

Top module: `e1_ra_bit_gen`

## Requirements
- R1: After reset, `a_bit_o` and `crc_lfa_o` are both 0.
- R2: With every control bit clear, `a_bit_o` is 0 after a strobe even when every receive condition is active. Control bit 6 enables nothing, so setting only bit 6 also gives 0.
- R3: With control bit 7 set, `a_bit_o` is 1 after a strobe regardless of the receive conditions.
- R4: With control bit 0 set, `a_bit_o` is 1 after a strobe while `lfa_fbe_i` is 1 or `crc_lfa_o` is 1, and 0 when both are 0.
- R5: With control bit 1 set, `a_bit_o` follows `lmf_ts16_i` at each strobe.
- R6: With control bit 2 set, `a_bit_o` follows `lmf_crc_i` at each strobe.
- R7: With control bit 3 set, `a_bit_o` is 1 after a strobe only if `lmf_crc_i` and `crc_tmr_exp_i` are both 1.
- R8: Control bit 4 gives `a_bit_o` = 1 when `sa6_code_i` is 4'h8 at the strobe. Control bit 5 does the same when it is 4'hC. Any other Sa6 code has no effect through either bit.
- R9: `a_bit_o` changes only in the cycle after `nfas_ts0_i` is high and holds its value in all other cycles, whatever the inputs do.
- R10: A window ends on its 1000th `crc_blk_valid_i` pulse. If 915 or more blocks of that window had `crc_blk_err_i` high, `crc_lfa_o` is 1 from the next cycle on. Both counts then restart for the next window.
- R11: Once set, `crc_lfa_o` stays 1 through later windows whatever their error counts. It returns to 0 the cycle after `realign_i` is high, unless a qualifying window ends in that same cycle.
- R12: A window that ends with 914 errored blocks leaves `crc_lfa_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_i | input | 8 | Control word: bit 7 forces the alarm; bits 0 to 5 enable the individual conditions |
| nfas_ts0_i | input | 1 | Pulse at the start of time slot 0 of a NOT FAS frame |
| lfa_fbe_i | input | 1 | Basic frame alignment lost because of framing bit errors |
| lmf_crc_i | input | 1 | CRC-4 multiframe alignment lost |
| lmf_ts16_i | input | 1 | Time slot 16 signalling multiframe alignment lost |
| crc_tmr_exp_i | input | 1 | CRC-4 multiframe search timer (100 ms or 400 ms) has expired |
| sa6_code_i | input | 4 | Decoded received Sa6 pattern |
| crc_blk_valid_i | input | 1 | One CRC-4 sub-multiframe block has been checked |
| crc_blk_err_i | input | 1 | The checked block was errored (qualified by valid) |
| realign_i | input | 1 | Framer reports basic frame alignment regained |
| a_bit_o | output | 1 | Remote alarm bit for the next NOT FAS time slot 0 |
| crc_lfa_o | output | 1 | CRC-4 errored-block loss of alignment indication |

## Verification
The hardest behaviour to reach from the ports is the CRC-4 errored-block declaration. Reaching it takes a full window of 1000 valid blocks, and the threshold has to be probed on both sides: 914 errored blocks must not set it and 915 must. The stimulus pulses a block on every cycle through complete windows with a chosen number of errored blocks. After a declaration it runs a clean window to show the indication is sticky, then pulses the realign input to clear it. Between these steps the bench strobes NOT FAS frames with only control bit 0 set, so the declaration is also seen at the alarm bit.

// File: rtl/ra_pkg.sv
package ra_pkg;

    // Control word bit positions (decoded by the register block)
    localparam int CB_LFA      = 0;
    localparam int CB_TS16     = 1;
    localparam int CB_CRCMF    = 2;
    localparam int CB_CRCTMR   = 3;
    localparam int CB_SA6_8    = 4;
    localparam int CB_SA6_C    = 5;
    localparam int CB_SPARE    = 6;
    localparam int CB_FORCE    = 7;
    localparam int CTRL_W      = 8;

    localparam logic [3:0] SA6_PAT_8 = 4'h8;
    localparam logic [3:0] SA6_PAT_C = 4'hC;

    typedef struct packed {
        logic       lfa_fbe;
        logic       lmf_crc;
        logic       lmf_ts16;
        logic       crc_tmr_exp;
        logic [3:0] sa6;
    } rx_stat_t;

    typedef logic [CTRL_W-1:0] cond_vec_t;

    function automatic logic sa6_is(input logic [3:0] code, input logic [3:0] pat);
        return code == pat;
    endfunction

endpackage

// File: rtl/ra_crc_blk_mon.sv
module ra_crc_blk_mon #(
    parameter int WINDOW = 1000,
    parameter int THRESH = 915
) (
    input  logic clk,
    input  logic rst,
    input  logic blk_valid,
    input  logic blk_err,
    input  logic realign,
    output logic crc_lfa
);
    localparam int CW = $clog2(WINDOW + 1);

    logic [CW-1:0] blk_cnt;
    logic [CW-1:0] err_cnt;
    logic [CW-1:0] err_total;
    logic          win_end;
    logic          trip;
    logic          crc_lfa_q;

    assign win_end   = blk_valid && (blk_cnt == CW'(WINDOW - 1));
    assign err_total = err_cnt + CW'(blk_err);
    assign trip      = win_end && (err_total >= CW'(THRESH));

    always_ff @(posedge clk) begin
        if (rst) begin
            blk_cnt <= '0;
            err_cnt <= '0;
        end else if (blk_valid) begin
            if (win_end) begin
                blk_cnt <= '0;
                err_cnt <= '0;
            end else begin
                blk_cnt <= blk_cnt + 1'b1;
                err_cnt <= err_total;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          crc_lfa_q <= 1'b0;
        else if (trip)    crc_lfa_q <= 1'b1;
        else if (realign) crc_lfa_q <= 1'b0;
    end

    assign crc_lfa = crc_lfa_q;

    // R10: indication rises only at a window end
    a_r10_rise_at_end: assert property (@(posedge clk) disable iff (rst)
        $rose(crc_lfa_q) |-> $past(win_end));
    // R11: indication falls only after realign
    a_r11_fall_on_realign: assert property (@(posedge clk) disable iff (rst)
        $fell(crc_lfa_q) |-> $past(realign));
    // R10: counters stay inside the window
    a_r10_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        (blk_cnt < CW'(WINDOW)) && (err_cnt <= blk_cnt));

endmodule

// File: rtl/ra_cond_mux.sv
module ra_cond_mux
    import ra_pkg::*;
(
    input  logic [CTRL_W-1:0] ctrl,
    input  rx_stat_t          stat,
    input  logic              crc_lfa,
    output cond_vec_t         cond_vec
);
    cond_vec_t raw;

    always_comb begin
        raw             = '0;
        raw[CB_LFA]     = stat.lfa_fbe | crc_lfa;
        raw[CB_TS16]    = stat.lmf_ts16;
        raw[CB_CRCMF]   = stat.lmf_crc;
        raw[CB_CRCTMR]  = stat.lmf_crc & stat.crc_tmr_exp;
        raw[CB_SA6_8]   = sa6_is(stat.sa6, SA6_PAT_8);
        raw[CB_SA6_C]   = sa6_is(stat.sa6, SA6_PAT_C);
        raw[CB_SPARE]   = 1'b0;
        raw[CB_FORCE]   = 1'b1;
    end

    for (genvar i = 0; i < CTRL_W; i++) begin : g_mask
        assign cond_vec[i] = raw[i] & ctrl[i];
    end

endmodule

// File: rtl/ra_bit_sampler.sv
module ra_bit_sampler
    import ra_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      strobe,
    input  cond_vec_t cond_vec,
    output logic      a_bit
);
    logic a_q;

    always_ff @(posedge clk) begin
        if (rst)         a_q <= 1'b0;
        else if (strobe) a_q <= |cond_vec;
    end

    assign a_bit = a_q;

    // R9: value held between strobes
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        !strobe |=> $stable(a_q));
    // R3: forced alarm appears after the strobe
    a_r3_force: assert property (@(posedge clk) disable iff (rst)
        (strobe && cond_vec[CB_FORCE]) |=> a_q);

endmodule

// File: rtl/e1_ra_bit_gen.sv
module e1_ra_bit_gen
    import ra_pkg::*;
#(
    parameter int WINDOW = 1000,
    parameter int THRESH = 915
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] ctrl_i,
    input  logic       nfas_ts0_i,
    input  logic       lfa_fbe_i,
    input  logic       lmf_crc_i,
    input  logic       lmf_ts16_i,
    input  logic       crc_tmr_exp_i,
    input  logic [3:0] sa6_code_i,
    input  logic       crc_blk_valid_i,
    input  logic       crc_blk_err_i,
    input  logic       realign_i,
    output logic       a_bit_o,
    output logic       crc_lfa_o
);
    rx_stat_t  stat;
    cond_vec_t cond_vec;
    logic      crc_lfa;

    assign stat = '{lfa_fbe:     lfa_fbe_i,
                    lmf_crc:     lmf_crc_i,
                    lmf_ts16:    lmf_ts16_i,
                    crc_tmr_exp: crc_tmr_exp_i,
                    sa6:         sa6_code_i};

    ra_crc_blk_mon #(.WINDOW(WINDOW), .THRESH(THRESH)) u_mon (
        .clk       (clk),
        .rst       (rst),
        .blk_valid (crc_blk_valid_i),
        .blk_err   (crc_blk_err_i),
        .realign   (realign_i),
        .crc_lfa   (crc_lfa)
    );

    ra_cond_mux u_mux (
        .ctrl     (ctrl_i),
        .stat     (stat),
        .crc_lfa  (crc_lfa),
        .cond_vec (cond_vec)
    );

    ra_bit_sampler u_smp (
        .clk      (clk),
        .rst      (rst),
        .strobe   (nfas_ts0_i),
        .cond_vec (cond_vec),
        .a_bit    (a_bit_o)
    );

    assign crc_lfa_o = crc_lfa;

    // R2: nothing enabled means no alarm
    a_r2_masked: assert property (@(posedge clk) disable iff (rst)
        (nfas_ts0_i && ctrl_i[5:0] == 6'd0 && !ctrl_i[7]) |=> !a_bit_o);
    // R7: timer-qualified condition alone needs both inputs
    a_r7_tmr: assert property (@(posedge clk) disable iff (rst)
        (nfas_ts0_i && ctrl_i == 8'h08 && !(lmf_crc_i && crc_tmr_exp_i)) |=> !a_bit_o);

endmodule

// File: tb/tb_e1_ra_bit_gen.sv
`timescale 1ns/1ps
module tb_e1_ra_bit_gen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] ctrl = '0;
    logic       nfas = 1'b0;
    logic       lfa_fbe = 1'b0, lmf_crc = 1'b0, lmf_ts16 = 1'b0, tmr = 1'b0;
    logic [3:0] sa6 = '0;
    logic       bv = 1'b0, be = 1'b0, realign = 1'b0;
    logic       a_bit, crc_lfa;

    always #2 clk = ~clk;

    e1_ra_bit_gen dut (
        .clk(clk), .rst(rst), .ctrl_i(ctrl), .nfas_ts0_i(nfas),
        .lfa_fbe_i(lfa_fbe), .lmf_crc_i(lmf_crc), .lmf_ts16_i(lmf_ts16),
        .crc_tmr_exp_i(tmr), .sa6_code_i(sa6),
        .crc_blk_valid_i(bv), .crc_blk_err_i(be), .realign_i(realign),
        .a_bit_o(a_bit), .crc_lfa_o(crc_lfa)
    );

    typedef struct {
        longint due;
        string  req;
        logic   a;
        logic   lfa;
    } exp_t;

    exp_t   q[$];
    longint cyc = 0;
    int     n_chk = 0, n_fail = 0;
    bit     done = 1'b0;
    logic   exp_lfa = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: compare due items away from the active edge
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due <= cyc) begin
            exp_t it;
            it = q.pop_front();
            n_chk++;
            if (a_bit !== it.a || crc_lfa !== it.lfa) begin
                n_fail++;
                $display("FAIL %s: a_bit=%b crc_lfa=%b expected a_bit=%b crc_lfa=%b",
                         it.req, a_bit, crc_lfa, it.a, it.lfa);
            end
        end
    end

    task automatic push(input string req, input logic a, input int dly);
        exp_t it;
        it.due = cyc + dly; it.req = req; it.a = a; it.lfa = exp_lfa;
        q.push_back(it);
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    // one NOT FAS strobe, expected alarm bit given
    task automatic frame(input string req, input logic a);
        @(negedge clk);
        nfas = 1'b1;
        push(req, a, 1);
        @(negedge clk);
        nfas = 1'b0;
        settle();
    endtask

    task automatic window(input int nerr);
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            bv = 1'b1;
            be = (i % 2 == 0) ? (i / 2 < nerr) : ((500 + i / 2) < nerr);
        end
        @(negedge clk);
        bv = 1'b0; be = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: run did not finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic a_prev;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        push("R1 reset", 1'b0, 1);
        settle();

        // R2: all conditions active, nothing enabled
        lfa_fbe = 1; lmf_crc = 1; lmf_ts16 = 1; tmr = 1; sa6 = 4'h8;
        ctrl = 8'h00; frame("R2 all masked", 1'b0);
        ctrl = 8'h40; frame("R2 spare bit 6", 1'b0);
        sa6 = 4'hC;   frame("R2 spare bit 6 sa6 C", 1'b0);

        // R3 force
        lfa_fbe = 0; lmf_crc = 0; lmf_ts16 = 0; tmr = 0; sa6 = 4'h0;
        ctrl = 8'h80; frame("R3 force", 1'b1);

        // R9: no strobe, inputs change, value holds
        ctrl = 8'h00; lfa_fbe = 1;
        push("R9 hold", 1'b1, 1);
        push("R9 hold later", 1'b1, 3);
        settle(); settle();
        frame("R9 update on strobe", 1'b0);
        lfa_fbe = 0;

        // R4
        ctrl = 8'h01; lfa_fbe = 1; frame("R4 fbe", 1'b1);
        lfa_fbe = 0;              frame("R4 clear", 1'b0);
        // R5
        ctrl = 8'h02; lmf_ts16 = 1; frame("R5 ts16", 1'b1);
        lmf_ts16 = 0;               frame("R5 clear", 1'b0);
        // R6
        ctrl = 8'h04; lmf_crc = 1; frame("R6 crc mf", 1'b1);
        lmf_crc = 0;               frame("R6 clear", 1'b0);
        // R7
        ctrl = 8'h08; lmf_crc = 1; tmr = 0; frame("R7 no timer", 1'b0);
        tmr = 1;                            frame("R7 timer", 1'b1);
        lmf_crc = 0;                        frame("R7 timer only", 1'b0);
        tmr = 0;
        // R8
        ctrl = 8'h10; sa6 = 4'h8; frame("R8 sa6 8", 1'b1);
        sa6 = 4'hC;               frame("R8 bit4 sa6 C", 1'b0);
        ctrl = 8'h20;             frame("R8 sa6 C", 1'b1);
        sa6 = 4'h8;               frame("R8 bit5 sa6 8", 1'b0);
        ctrl = 8'h30; sa6 = 4'h4; frame("R8 other code", 1'b0);
        sa6 = 4'h0;

        // R12: 914 errored
        ctrl = 8'h01;
        window(914);
        push("R12 914 no set", 1'b0, 1);
        settle();
        frame("R12 alarm stays 0", 1'b0);

        // R10: 915 errored
        window(915);
        exp_lfa = 1'b1;
        push("R10 915 set", 1'b0, 1);
        settle();
        frame("R10 R4 alarm from crc lfa", 1'b1);

        // R11: sticky through a clean window
        window(0);
        push("R11 sticky", 1'b1, 1);
        settle();
        @(negedge clk); realign = 1'b1;
        @(negedge clk); realign = 1'b0;
        exp_lfa = 1'b0;
        push("R11 realign clears", 1'b1, 1);
        settle();
        frame("R11 R4 alarm clears", 1'b0);

        // R10 restart: fresh window after clear, all errored
        window(1000);
        exp_lfa = 1'b1;
        push("R10 restart set", 1'b0, 1);
        settle();

        a_prev = a_bit;
        repeat (5) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule